// File: doc/BRIEF.md
# Per-Core Soft Reset Sequencer

This controller runs a soft reset for each core of a multi-core cluster, and each core has its own sequence. A request for a core is held until that core reports that it is idle in wait-for-interrupt standby. The core's active-low reset is then driven low. A companion active-low auxiliary reset can be driven low with it, chosen per request. After a fixed short delay the core's power clamps are released. The reset is held for a minimum number of cycles, and then every reset that was asserted is released on one clock edge. A one-cycle completion pulse follows.

The controller also guards the shared L2 reset. That reset can only be applied while no core is active. A core counts as active when its reset is released and it is not reporting standby. An L2 reset request made while any core is active is held off and flagged. The power-down steps that come before a core request are outside this block, and only the standby input stands for them. The debug, trace and debug-bus reset domains have no pins here, so they are never driven.

Top module: `soft_reset_sequencer`

## Requirements
- R1: A core's reset `core_rst_n[i]` goes low only on a clock edge at which `core_standby[i]` is sampled high, with the request already pending. While standby stays low, the pending request waits and the reset stays high.
- R2: `seq_aux_en[i]` is sampled together with the accepted request. When it is 1, `aux_rst_n[i]` goes low and high on the same edges as `core_rst_n[i]`. When it is 0, `aux_rst_n[i]` stays high for the whole sequence.
- R3: `clamp_release[i]` rises exactly CLAMP_DELAY (default 5) cycles after the reset edge. It then stays high until the cycle of the completion pulse, when it falls.
- R4: `core_rst_n[i]` stays low for exactly HOLD_CYCLES cycles (default 16). A HOLD_CYCLES value below 16, or one not greater than CLAMP_DELAY+1, is rejected at elaboration.
- R5: When the auxiliary reset was asserted, both resets are released on the same clock edge.
- R6: `l2_rst_n` is low in a cycle only if, at the previous edge, `l2_req` was high and every core had either its reset low or its standby high.
- R7: `l2_blocked` is high in a cycle exactly when, at the previous edge, `l2_req` was high and at least one core was active. `l2_rst_n` stays high during that cycle.
- R8: Each core's sequence is independent. Requests, standby and timing on one core do not change the outputs of the other cores.
- R9: After the controller's own reset, every `core_rst_n`, `aux_rst_n` and `l2_rst_n` is high, and every `clamp_release`, `seq_done` and `l2_blocked` is low.
- R10: `seq_done[i]` is high for exactly one cycle, in the cycle after the reset release edge.
- R11: A request for a core that is already in a sequence is ignored until that core is idle again. The first edge at which a new request is accepted is the one after the `seq_done` pulse begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller power-on reset, active low, asynchronous assert |
| seq_req | input | NUM_CORES | Per-core soft reset request, sampled when the core is idle |
| seq_aux_en | input | NUM_CORES | Per-core selection of the auxiliary reset, sampled with the request |
| core_standby | input | NUM_CORES | Per-core wait-for-interrupt standby indication |
| core_rst_n | output | NUM_CORES | Per-core reset, active low, registered |
| aux_rst_n | output | NUM_CORES | Per-core auxiliary reset, active low, registered |
| clamp_release | output | NUM_CORES | Per-core power clamp release, registered |
| seq_done | output | NUM_CORES | Per-core one-cycle completion pulse |
| l2_req | input | 1 | Request to hold the shared L2 reset |
| l2_rst_n | output | 1 | Shared L2 reset, active low, registered |
| l2_blocked | output | 1 | L2 reset request is being held off because a core is active |

## Verification
The hardest case to reach from the ports is the L2 interlock boundary. Every core must be inactive, with some inactive because they are in reset and others because they report standby. The verdict must then flip as soon as a single core leaves that set. The stimulus holds one core inside its reset window and sets standby on the rest. It then drops one standby, and later lets the reset core finish, so that its reset release makes it active again. Re-requests are also issued in the middle of a sequence and on the done-pulse edge. A behavioural model that tracks each core's time since its reset edge is compared with all outputs on every cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_STBY,
    ST_ASSERT,
    ST_CLAMP,
    ST_HOLD,
    ST_RELEASE
  } seq_state_e;

  function automatic logic holds_reset(seq_state_e s);
    return (s == ST_ASSERT) || (s == ST_CLAMP) || (s == ST_HOLD);
  endfunction

  function automatic logic clamps_open(seq_state_e s);
    return (s == ST_CLAMP) || (s == ST_HOLD) || (s == ST_RELEASE);
  endfunction

endpackage

// File: rtl/srs_core_fsm.sv
module srs_core_fsm #(
  parameter int HOLD_CYCLES = 16,
  parameter int CLAMP_DELAY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_aux,
  input  logic standby,
  output logic core_rst_n,
  output logic aux_rst_n,
  output logic clamp_release,
  output logic done
);
  import srs_pkg::*;

  localparam int CW = $clog2(HOLD_CYCLES + 2);
  localparam logic [CW-1:0] CLAMP_AT = CW'(CLAMP_DELAY);
  localparam logic [CW-1:0] HOLD_AT  = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] RUN_MAX  = CW'(HOLD_CYCLES + 1);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic            aux_sel_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req)              state_d = ST_WAIT_STBY;
      ST_WAIT_STBY: if (standby)          state_d = ST_ASSERT;
      ST_ASSERT:    if (cnt_q == CLAMP_AT) state_d = ST_CLAMP;
      ST_CLAMP:                           state_d = ST_HOLD;
      ST_HOLD:      if (cnt_q == HOLD_AT)  state_d = ST_RELEASE;
      ST_RELEASE:                         state_d = ST_IDLE;
      default:                            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      aux_sel_q     <= 1'b0;
      core_rst_n    <= 1'b1;
      aux_rst_n     <= 1'b1;
      clamp_release <= 1'b0;
      done          <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req) aux_sel_q <= req_aux;
      if (state_q == ST_WAIT_STBY && state_d == ST_ASSERT) cnt_q <= CW'(1);
      else if (holds_reset(state_q))                       cnt_q <= cnt_q + CW'(1);
      else                                                 cnt_q <= '0;
      core_rst_n    <= !holds_reset(state_d);
      aux_rst_n     <= !(aux_sel_q && holds_reset(state_d));
      clamp_release <= clamps_open(state_d);
      done          <= (state_q == ST_RELEASE);
    end
  end

  // Independent low-run counter used only by the checks below.
  logic [CW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_run_q <= '0;
    else if (core_rst_n)      low_run_q <= '0;
    else if (low_run_q != RUN_MAX) low_run_q <= low_run_q + CW'(1);
  end

  AST_RESET_NEEDS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_n) |-> $past(standby)); // R1
  AST_AUX_INSIDE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_rst_n |-> !core_rst_n); // R2
  AST_CLAMP_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_release) |-> (!core_rst_n && low_run_q == CLAMP_AT)); // R3
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> (low_run_q >= HOLD_AT)); // R4
  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_rst_n) |-> $rose(core_rst_n)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(core_rst_n) && !clamp_release); // R10

endmodule

// File: rtl/srs_l2_interlock.sv
module srs_l2_interlock #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 l2_req,
  input  logic [NUM_CORES-1:0] core_rst_n,
  input  logic [NUM_CORES-1:0] core_standby,
  output logic                 l2_rst_n,
  output logic                 l2_blocked
);

  logic [NUM_CORES-1:0] active;
  logic                 any_active;

  assign active     = core_rst_n & ~core_standby;
  assign any_active = |active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_rst_n   <= 1'b1;
      l2_blocked <= 1'b0;
    end else begin
      l2_rst_n   <= !(l2_req && !any_active);
      l2_blocked <= l2_req && any_active;
    end
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    AST_L2_CORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !l2_rst_n |-> $past(!core_rst_n[i] || core_standby[i])); // R6
  end

  AST_L2_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    l2_blocked |-> l2_rst_n); // R7
  AST_L2_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!l2_rst_n || l2_blocked) |-> $past(l2_req)); // R7

endmodule

// File: rtl/soft_reset_sequencer.sv
module soft_reset_sequencer #(
  parameter int NUM_CORES   = 4,
  parameter int HOLD_CYCLES = 16,
  parameter int CLAMP_DELAY = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] seq_req,
  input  logic [NUM_CORES-1:0] seq_aux_en,
  input  logic [NUM_CORES-1:0] core_standby,
  output logic [NUM_CORES-1:0] core_rst_n,
  output logic [NUM_CORES-1:0] aux_rst_n,
  output logic [NUM_CORES-1:0] clamp_release,
  output logic [NUM_CORES-1:0] seq_done,
  input  logic                 l2_req,
  output logic                 l2_rst_n,
  output logic                 l2_blocked
);

  localparam int MIN_HOLD = 16;

  if (HOLD_CYCLES < MIN_HOLD) begin : g_hold_too_short
    $error("HOLD_CYCLES must be at least 16");
  end
  if (CLAMP_DELAY + 1 >= HOLD_CYCLES || CLAMP_DELAY < 1) begin : g_clamp_bad
    $error("CLAMP_DELAY must be at least 1 and below HOLD_CYCLES-1");
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    srs_core_fsm #(
      .HOLD_CYCLES (HOLD_CYCLES),
      .CLAMP_DELAY (CLAMP_DELAY)
    ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req           (seq_req[i]),
      .req_aux       (seq_aux_en[i]),
      .standby       (core_standby[i]),
      .core_rst_n    (core_rst_n[i]),
      .aux_rst_n     (aux_rst_n[i]),
      .clamp_release (clamp_release[i]),
      .done          (seq_done[i])
    );
  end

  srs_l2_interlock #(
    .NUM_CORES (NUM_CORES)
  ) u_l2 (
    .clk          (clk),
    .rst_n        (rst_n),
    .l2_req       (l2_req),
    .core_rst_n   (core_rst_n),
    .core_standby (core_standby),
    .l2_rst_n     (l2_rst_n),
    .l2_blocked   (l2_blocked)
  );

endmodule

// File: tb/test_soft_reset_sequencer.sv
module test_soft_reset_sequencer;

  localparam int NC    = 4;
  localparam int HOLD  = 16;
  localparam int CLAMP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] seq_req = '0, seq_aux_en = '0, core_standby = '0;
  logic [NC-1:0] core_rst_n, aux_rst_n, clamp_release, seq_done;
  logic          l2_req = 1'b0;
  logic          l2_rst_n, l2_blocked;

  always #2.5 clk = ~clk;

  soft_reset_sequencer #(.NUM_CORES(NC), .HOLD_CYCLES(HOLD), .CLAMP_DELAY(CLAMP)) i_soft_reset_sequencer (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_aux_en(seq_aux_en),
    .core_standby(core_standby), .core_rst_n(core_rst_n), .aux_rst_n(aux_rst_n),
    .clamp_release(clamp_release), .seq_done(seq_done), .l2_req(l2_req),
    .l2_rst_n(l2_rst_n), .l2_blocked(l2_blocked));

  int vectors = 0;
  int fails   = 0;
  bit reported = 0;

  // Behavioural reference: per core, busy/waiting flags and time since the reset edge.
  bit            m_busy[NC], m_wait[NC], m_aux[NC];
  int            m_t[NC];
  logic [NC-1:0] e_core = '1, e_aux = '1, e_clamp = '0, e_done = '0;
  logic          e_l2 = 1'b1, e_blk = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_busy[i] = 0; m_wait[i] = 0; m_aux[i] = 0; m_t[i] = 0; end
      e_core = '1; e_aux = '1; e_clamp = '0; e_done = '0; e_l2 = 1'b1; e_blk = 1'b0;
    end else begin
      bit any_act;
      any_act = 0;
      for (int i = 0; i < NC; i++) if (e_core[i] && !core_standby[i]) any_act = 1;
      e_l2  = !(l2_req && !any_act);
      e_blk = l2_req && any_act;
      for (int i = 0; i < NC; i++) begin
        bit ended, low;
        ended = 0;
        if (!m_busy[i]) begin
          if (seq_req[i]) begin m_busy[i] = 1; m_wait[i] = 1; m_aux[i] = seq_aux_en[i]; end
        end else if (m_wait[i]) begin
          if (core_standby[i]) begin m_wait[i] = 0; m_t[i] = 0; end
        end else begin
          m_t[i]++;
          if (m_t[i] == HOLD + 1) begin m_busy[i] = 0; ended = 1; end
        end
        low        = m_busy[i] && !m_wait[i] && m_t[i] < HOLD;
        e_core[i]  = !low;
        e_aux[i]   = !(low && m_aux[i]);
        e_clamp[i] = m_busy[i] && !m_wait[i] && m_t[i] >= CLAMP;
        e_done[i]  = ended;
      end
    end
  end

  task automatic chk(string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R4 core_rst_n",  core_rst_n,    e_core);
      chk("R2/R5 aux_rst_n",   aux_rst_n,     e_aux);
      chk("R3 clamp_release",  clamp_release, e_clamp);
      chk("R10 seq_done",      seq_done,      e_done);
      chk("R6 l2_rst_n",       NC'(l2_rst_n), NC'(e_l2));
      chk("R7 l2_blocked",     NC'(l2_blocked), NC'(e_blk));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    // R9: reset values
    chk("R9 core_rst_n reset", core_rst_n, '1);
    chk("R9 aux_rst_n reset", aux_rst_n, '1);
    chk("R9 clamp/done reset", clamp_release | seq_done, '0);
    chk("R9 l2 reset", NC'({l2_rst_n, l2_blocked}), NC'(2'b10));
    rst_n = 1'b1;
    cyc(2);

    // R1, R2: core 0 with aux, standby arrives late
    seq_req[0] = 1; seq_aux_en[0] = 1; cyc(1); seq_req[0] = 0; seq_aux_en[0] = 0;
    cyc(7);
    core_standby[0] = 1;
    cyc(10);
    // R11: re-request mid-sequence is ignored
    seq_req[0] = 1; cyc(3); seq_req[0] = 0;
    cyc(20);

    // R8: core 1 without aux, standby already high, core 2 staggered with aux
    core_standby[1] = 1; core_standby[2] = 1;
    seq_req[1] = 1; cyc(1); seq_req[1] = 0;
    cyc(4);
    seq_req[2] = 1; seq_aux_en[2] = 1; cyc(1); seq_req[2] = 0; seq_aux_en[2] = 0;
    cyc(10);
    // R11: hold request high through the done edge so it is accepted right after
    seq_req[1] = 1;
    cyc(12);
    seq_req[1] = 0;
    cyc(25);

    // R7: L2 request while core 3 is active
    core_standby = 4'b0111;
    l2_req = 1; cyc(6);
    // R6: every core in standby
    core_standby = 4'b1111; cyc(5);
    core_standby = 4'b1011; cyc(4);
    // R6: core 3 inactive by being in reset, others in standby
    core_standby = 4'b1111;
    seq_req[3] = 1; cyc(1); seq_req[3] = 0;
    cyc(2);
    core_standby[3] = 0;     // still in reset, so not active
    cyc(8);
    core_standby[1] = 0;     // core 1 becomes active
    cyc(3);
    core_standby[1] = 1;
    cyc(15);                 // core 3 leaves reset with standby low: active again
    l2_req = 0; cyc(3);

    // R8: all cores together, mixed aux
    core_standby = '1;
    seq_req = 4'b1111; seq_aux_en = 4'b0101; cyc(1); seq_req = '0; seq_aux_en = '0;
    cyc(25);
    finish_run();
  end

endmodule